// File: doc/BRIEF.md
# USB Host Controller Interrupt Enable Register

This block holds the interrupt enable mask of a USB host controller's operational register space and turns it, together with the controller's event status lines, into one level-sensitive interrupt request. Software reaches the mask through a simple register bus that has a valid strobe, a write strobe, a word address and 32-bit data. Two word offsets map onto the same mask. At the set offset, every data bit written as 1 turns the matching enable on. At the clear offset, every data bit written as 1 turns the matching enable off. A 0 in the data leaves the bit as it was at either offset, so software can change single enables without a read-modify-write.

The mask has a master enable in the top bit and an ownership-change enable just below it. The lowest bits carry one enable per controller event. All bits between them are reserved: they hold no storage and always read 0. The interrupt output is a flop. It is asserted when the master enable is on and at least one event has both its status line and its enable set. It follows changes in status or mask one clock later.

Top module: `hcie_top`

## Requirements
- R1: After a synchronous active-high reset, every enable bit is 0, `irq_out` is 0 and `bus_rdata` is 0.
- R2: A write at word address SET_WORD (default 4) sets each implemented enable bit whose data bit is 1. Bits written 0 keep their value, so this offset can never clear a bit.
- R3: A write at word address CLR_WORD (default 5) clears each enable bit whose data bit is 1. Bits written 0 keep their value.
- R4: Reserved bits (positions EVT_W up to DATA_W-3, default 7..29) ignore writes at both offsets and always read 0. With all ones written, the mask reads 32'hC000_007F.
- R5: A read at either mapped offset loads the current mask into `bus_rdata` at the next clock edge. A read at any other address loads 0. Writes to other addresses change nothing. `bus_rdata` holds its value when no read is issued.
- R6: At every clock edge, `irq_out` is loaded with the gating result of the status inputs and mask as they were before that edge. It stays high for as long as the condition holds.
- R7: While the master enable (bit DATA_W-1, bit 31) is 0, `irq_out` stays 0 whatever the status inputs are.
- R8: The ownership-change event has its own status input `own_status`. Enable bit DATA_W-2 (bit 30) gates it, together with the master enable.
- R9: Status line `evt_status[i]` is gated only by enable bit i. With the default EVT_W=7, bit 6 is root hub status change, bit 5 is frame number overflow, bit 4 is unrecoverable error, bit 3 is resume detected, bit 2 is start of frame, bit 1 is writeback done head and bit 0 is scheduling overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| evt_status | input | EVT_W (7) | Event status lines, one per low enable bit |
| own_status | input | 1 | Ownership-change status line |
| irq_out | output | 1 | Registered level-sensitive interrupt request |

## Verification
The bench uses the default parameters: DATA_W=32, EVT_W=7, ADDR_W=4, with the set and clear offsets at words 4 and 5. These values make the full 23-bit reserved gap, the two top control bits and all seven event positions observable. Unmapped addresses 0 and 7 are also reachable, so stray accesses can be checked against the mask. Random 32-bit write data hits the master bit about half the time, so the gated and the blocked interrupt paths both come up often during the random run.

// File: rtl/hcie_pkg.sv
package hcie_pkg;

  localparam int MAX_W = 64;

  // Mask of implemented enable bits: events at the bottom,
  // ownership-change and master at the top, gap reserved.
  function automatic logic [MAX_W-1:0] impl_mask(input int data_w, input int evt_w);
    logic [MAX_W-1:0] m;
    m = '0;
    for (int i = 0; i < evt_w; i++) m[i] = 1'b1;
    m[data_w-1] = 1'b1;
    m[data_w-2] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic set_we;
    logic clr_we;
    logic rd_hit;
    logic rd_miss;
  } bus_strobe_t;

endpackage

// File: rtl/hcie_bus_decode.sv
module hcie_bus_decode #(
  parameter int ADDR_W   = 4,
  parameter int SET_WORD = 4,
  parameter int CLR_WORD = 5
) (
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  output hcie_pkg::bus_strobe_t strb
);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_WORD);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_WORD);

  logic hit_set, hit_clr;

  always_comb begin
    hit_set      = (bus_addr == SET_A);
    hit_clr      = (bus_addr == CLR_A);
    strb.set_we  = bus_valid &&  bus_write && hit_set;
    strb.clr_we  = bus_valid &&  bus_write && hit_clr;
    strb.rd_hit  = bus_valid && !bus_write && (hit_set || hit_clr);
    strb.rd_miss = bus_valid && !bus_write && !(hit_set || hit_clr);
  end

endmodule

// File: rtl/hcie_enable_reg.sv
module hcie_enable_reg #(
  parameter int DATA_W = 32,
  parameter int EVT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);
  localparam logic [hcie_pkg::MAX_W-1:0] IMPL_W = hcie_pkg::impl_mask(DATA_W, EVT_W);
  localparam logic [DATA_W-1:0] IMPL = IMPL_W[DATA_W-1:0];

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (IMPL[b]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)                      bit_q <= 1'b0;
        else if (clr_we && wdata[b])  bit_q <= 1'b0;   // clear beats set
        else if (set_we && wdata[b])  bit_q <= 1'b1;
      end
      assign en_q[b] = bit_q;
    end else begin : g_rsvd
      assign en_q[b] = 1'b0;
    end
  end

  // R2: bits written 1 at the set offset are on afterwards
  a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
    (set_we && !clr_we) |=> ((en_q & $past(wdata & IMPL)) == $past(wdata & IMPL)));

  // R2: the set offset never turns a bit off
  a_r2_set_only: assert property (@(posedge clk) disable iff (rst)
    (set_we && !clr_we) |=> ((en_q & $past(en_q)) == $past(en_q)));

  // R3: bits written 1 at the clear offset are off afterwards
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((en_q & $past(wdata)) == '0));

  // R3: bits written 0 at the clear offset are untouched
  a_r3_clear_keeps: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));

  // R5: without a mapped write the mask holds
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(en_q));

endmodule

// File: rtl/hcie_irq_gate.sv
module hcie_irq_gate #(
  parameter int DATA_W = 32,
  parameter int EVT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] en_q,
  input  logic [EVT_W-1:0]  evt_status,
  input  logic              own_status,
  output logic              irq_out
);
  localparam int MST_BIT = DATA_W - 1;
  localparam int OWN_BIT = DATA_W - 2;

  logic [EVT_W-1:0] evt_live;
  logic             own_live;
  logic             irq_d;

  always_comb begin
    evt_live = evt_status & en_q[EVT_W-1:0];
    own_live = own_status & en_q[OWN_BIT];
    irq_d    = en_q[MST_BIT] & ((|evt_live) | own_live);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= irq_d;
  end

  // R7: master off blocks the request on the next edge
  a_r7_master_blocks: assert property (@(posedge clk) disable iff (rst)
    !en_q[MST_BIT] |=> !irq_out);

  // R8: enabled ownership change with master on raises the request
  a_r8_own_raises: assert property (@(posedge clk) disable iff (rst)
    (en_q[MST_BIT] && en_q[OWN_BIT] && own_status) |=> irq_out);

  // R6: no status and no ownership change means no request next cycle
  a_r6_quiet_low: assert property (@(posedge clk) disable iff (rst)
    (evt_status == '0 && !own_status) |=> !irq_out);

endmodule

// File: rtl/hcie_top.sv
module hcie_top #(
  parameter int DATA_W   = 32,
  parameter int EVT_W    = 7,
  parameter int ADDR_W   = 4,
  parameter int SET_WORD = 4,
  parameter int CLR_WORD = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EVT_W-1:0]  evt_status,
  input  logic              own_status,
  output logic              irq_out
);
  hcie_pkg::bus_strobe_t strb;
  logic [DATA_W-1:0]     en_q;

  hcie_bus_decode #(
    .ADDR_W(ADDR_W), .SET_WORD(SET_WORD), .CLR_WORD(CLR_WORD)
  ) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .strb(strb)
  );

  hcie_enable_reg #(.DATA_W(DATA_W), .EVT_W(EVT_W)) u_en (
    .clk(clk), .rst(rst), .set_we(strb.set_we), .clr_we(strb.clr_we),
    .wdata(bus_wdata), .en_q(en_q)
  );

  hcie_irq_gate #(.DATA_W(DATA_W), .EVT_W(EVT_W)) u_gate (
    .clk(clk), .rst(rst), .en_q(en_q), .evt_status(evt_status),
    .own_status(own_status), .irq_out(irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst)               bus_rdata <= '0;
    else if (strb.rd_hit)  bus_rdata <= en_q;
    else if (strb.rd_miss) bus_rdata <= '0;
  end

  // R5: a read at an unmapped address returns 0
  a_r5_miss_zero: assert property (@(posedge clk) disable iff (rst)
    strb.rd_miss |=> (bus_rdata == '0));

  // R5: without a read the data register holds
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

// File: tb/hcie_top_test.sv
module hcie_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int EVT_W  = 7;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] SETA = 4'd4;
  localparam logic [ADDR_W-1:0] CLRA = 4'd5;
  localparam logic [DATA_W-1:0] MASK = 32'hC000_007F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [EVT_W-1:0]  evt_status = '0;
  logic own_status = 1'b0;
  logic irq_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [DATA_W-1:0] en_m = '0;
  logic [DATA_W-1:0] rd_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcie_top uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_status(evt_status), .own_status(own_status), .irq_out(irq_out)
  );

  function automatic logic gate(input logic [DATA_W-1:0] en,
                                input logic [EVT_W-1:0] st, input logic os);
    return en[31] && ((|(st & en[EVT_W-1:0])) || (os && en[30]));
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle from a negedge, update the model at the edge, check at next negedge.
  task automatic cyc(input logic v, input logic w, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] d, input logic [EVT_W-1:0] st,
                     input logic os);
    logic exp_irq;
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    evt_status = st; own_status = os;
    @(posedge clk);
    exp_irq = gate(en_m, st, os);
    if (v && !w) rd_m = (a == SETA || a == CLRA) ? en_m : '0;
    if (v && w) begin
      if (a == SETA) en_m = en_m | (d & MASK);
      else if (a == CLRA) en_m = en_m & ~d;
    end
    @(negedge clk);
    chk(irq_out === exp_irq, "R6 irq", {31'd0, irq_out}, {31'd0, exp_irq});
    chk(bus_rdata === rd_m, "R5 rdata", bus_rdata, rd_m);
    bus_valid = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag,
                    input logic [DATA_W-1:0] exp);
    cyc(1, 0, a, '0, evt_status, own_status);
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(irq_out === 1'b0, "R1 irq reset", {31'd0, irq_out}, 0);
    chk(bus_rdata === '0, "R1 rdata reset", bus_rdata, 0);
    rst = 1'b0;
    rd(SETA, "R1 mask reset", 32'h0);

    // R2 / R4: all ones lands only on implemented bits
    cyc(1, 1, SETA, 32'hFFFF_FFFF, '0, 0);
    rd(SETA, "R4 reserved read zero", 32'hC000_007F);
    rd(CLRA, "R5 clear offset readback", 32'hC000_007F);
    cyc(1, 1, SETA, 32'h0, '0, 0);
    rd(SETA, "R2 zero write keeps", 32'hC000_007F);
    // R3
    cyc(1, 1, CLRA, 32'h0000_0005, '0, 0);
    rd(SETA, "R3 clear selected", 32'hC000_007A);
    cyc(1, 1, CLRA, 32'h0, '0, 0);
    rd(SETA, "R3 zero clear keeps", 32'hC000_007A);
    // R5 unmapped
    cyc(1, 1, 4'd0, 32'h0000_0005, '0, 0);
    rd(4'd7, "R5 unmapped read zero", 32'h0);
    rd(SETA, "R5 unmapped write ignored", 32'hC000_007A);
    // R7 master off
    cyc(1, 1, CLRA, 32'h8000_0000, '0, 0);
    cyc(0, 0, '0, '0, 7'h7F, 1);
    cyc(0, 0, '0, '0, 7'h7F, 1);
    chk(irq_out === 1'b0, "R7 master off", {31'd0, irq_out}, 0);
    // R8 ownership change only
    cyc(1, 1, CLRA, 32'hFFFF_FFFF, '0, 0);
    cyc(1, 1, SETA, 32'hC000_0000, '0, 0);
    cyc(0, 0, '0, '0, '0, 1);
    chk(irq_out === 1'b1, "R8 own raises", {31'd0, irq_out}, 1);
    cyc(0, 0, '0, '0, 7'h7F, 0);
    chk(irq_out === 1'b0, "R9 events disabled", {31'd0, irq_out}, 0);
    // R9 position mapping: enable bit 3 only
    cyc(1, 1, CLRA, 32'h4000_0000, '0, 0);
    cyc(1, 1, SETA, 32'h0000_0008, '0, 0);
    cyc(0, 0, '0, '0, 7'h08, 0);
    chk(irq_out === 1'b1, "R9 bit3 routed", {31'd0, irq_out}, 1);
    cyc(0, 0, '0, '0, 7'h08, 0);
    chk(irq_out === 1'b1, "R6 level held", {31'd0, irq_out}, 1);
    cyc(0, 0, '0, '0, 7'h77, 1);
    chk(irq_out === 1'b0, "R9 other bits blocked", {31'd0, irq_out}, 0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a;
      logic [1:0] sel;
      sel = 2'($urandom_range(0, 3));
      a = (sel == 0) ? SETA : (sel == 1) ? CLRA : (sel == 2) ? 4'd0 : 4'd7;
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom(),
          7'($urandom()), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule